// File: doc/BRIEF.md
# Issue Interlock and Result-Latency Scoreboard

This block sits at the issue point of an in-order, single-issue pipeline. Each cycle it looks at one candidate instruction, described by a latency class, an optional destination register and up to three source registers, and it decides whether the instruction may issue now or must wait. For every architectural register it keeps a small down-counter. The counter holds the number of cycles that must still pass before a pending result can be forwarded to a consumer. A dependent instruction is held until every source it names is ready.

Some classes also occupy the execute stage for more than one cycle: register-amount shifts, multi-register loads and the multiplier loops. After such an instruction issues, the block refuses new issues for the extra cycles. The register counters keep counting down during that time. One path is faster than the rest. A single-word or byte load can supply the data operand of a store issued in the very next cycle, one cycle earlier than any other consumer could use it. This holds only when the loaded register is not also part of that store's address.

Top module: `issue_scoreboard`

## Requirements
- R1: While `rst` is high at a clock edge, every register counter and the execute-hold counter clear. In the first cycle after reset, `out_ready` is all ones and an instruction with any sources issues at once.
- R2: `out_issue` is high only when `in_valid` is high, no execute hold is active, and every enabled source is ready. `out_stall` equals `in_valid` and not `out_issue`. When the instruction is not accepted (not valid or stalled), no register state changes.
- R3: Class code 0 (plain ALU), and any unused code from 11 to 15 (treated as ALU), makes its destination ready in the cycle right after issue.
- R4: Class code 1 (ALU with a register-specified shift amount) makes its destination ready two cycles after issue. It also blocks every issue in the cycle right after it.
- R5: Class codes 2 (single-word/byte load) and 3 (two-register load) make their destination ready two cycles after issue. Class code 4 (three/four-register load) makes it ready three cycles after issue and blocks all issue for the two cycles after it.
- R6: A register loaded by class 2 counts as ready one cycle early, in the cycle right after the load, for one use only. That use is a class 5 store whose source slot 2 is enabled and flagged as store data (`in_src2_data`), where the same register is not named by an enabled source slot 0 or 1. Classes 3 and 4, non-store consumers and unflagged slots get no early use.
- R7: Class code 5 (store) produces no result. Its destination field never changes any register's state, and it holds no extra cycles.
- R8: Multiply classes, as (ready delay after issue, issue-blocked cycles after it): code 6 (2, 0), code 7 (3, 1), code 8 (3, 3), code 9 (4, 2), code 10 (4, 4).
- R9: While the execute hold blocks issue, register counters keep decreasing. A result whose delay ends inside the hold is ready by the time the hold ends.
- R10: An accepted instruction with `in_dst_en` low writes no register state. A newer write to a register replaces any older pending count (the newest result wins). Register 0 is tracked like every other register.
- R11: `out_ready[i]` is high exactly when register i has no remaining wait. It does not reflect the store-data early use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A candidate instruction is present |
| in_class | input | 4 | Latency class code (see R3 to R8) |
| in_dst | input | AW | Destination register index |
| in_dst_en | input | 1 | Instruction writes `in_dst` |
| in_src0 | input | AW | Source slot 0 (address-side operand) |
| in_src1 | input | AW | Source slot 1 (address-side operand) |
| in_src2 | input | AW | Source slot 2 (may carry store data) |
| in_src_en | input | 3 | Per-slot enable, bit k for slot k |
| in_src2_data | input | 1 | Slot 2 is the data operand of a store |
| out_issue | output | 1 | Instruction accepted this cycle |
| out_stall | output | 1 | Instruction present but held |
| out_ready | output | NREGS | Per-register result-ready flags |

## Verification
A counter that is too high, or a hold that lasts too long, shows at the ports as an extra `out_stall` cycle on the very next dependent instruction. A counter that is too low, or a missing hold, shows as `out_issue` one cycle early, and a wrong class latency shifts the first accepted cycle by exactly the error. The early store-data path is probed on both sides of its condition, so a bypass that is missing, too broad or ignores the address conflict changes the issue decision in the cycle right after the load. Invalid, stalled, store and write-disabled instructions are each followed by an immediate consumer of the register they might have touched, so a stray write shows up within one cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int LAT_W  = 3;
    localparam int HOLD_W = 3;
    localparam int CLS_W  = 4;
    localparam int NSRC   = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU   = 4'd0,
        CLS_SHREG = 4'd1,
        CLS_LD1   = 4'd2,
        CLS_LD2   = 4'd3,
        CLS_LDM   = 4'd4,
        CLS_ST    = 4'd5,
        CLS_MULH  = 4'd6,
        CLS_MUL   = 4'd7,
        CLS_MULF  = 4'd8,
        CLS_MULL  = 4'd9,
        CLS_MULLF = 4'd10
    } op_cls_e;

    typedef struct packed {
        logic [LAT_W-1:0]  wait_cyc;
        logic [HOLD_W-1:0] hold_cyc;
        logic              writes;
        logic              fwd_store;
    } cls_info_t;

    function automatic cls_info_t mk_info(input int w, input int h,
                                          input logic wr, input logic fw);
        cls_info_t r;
        r.wait_cyc  = LAT_W'(w);
        r.hold_cyc  = HOLD_W'(h);
        r.writes    = wr;
        r.fwd_store = fw;
        return r;
    endfunction

    function automatic cls_info_t cls_lookup(input logic [CLS_W-1:0] cls);
        cls_info_t r;
        case (cls)
            CLS_SHREG: r = mk_info(1, 1, 1'b1, 1'b0);
            CLS_LD1:   r = mk_info(1, 0, 1'b1, 1'b1);
            CLS_LD2:   r = mk_info(1, 0, 1'b1, 1'b0);
            CLS_LDM:   r = mk_info(2, 2, 1'b1, 1'b0);
            CLS_ST:    r = mk_info(0, 0, 1'b0, 1'b0);
            CLS_MULH:  r = mk_info(1, 0, 1'b1, 1'b0);
            CLS_MUL:   r = mk_info(2, 1, 1'b1, 1'b0);
            CLS_MULF:  r = mk_info(2, 3, 1'b1, 1'b0);
            CLS_MULL:  r = mk_info(3, 2, 1'b1, 1'b0);
            CLS_MULLF: r = mk_info(3, 4, 1'b1, 1'b0);
            default:   r = mk_info(0, 0, 1'b1, 1'b0);
        endcase
        return r;
    endfunction

    function automatic logic is_store(input logic [CLS_W-1:0] cls);
        return cls == CLS_ST;
    endfunction

endpackage

// File: rtl/sb_reg_slot.sv
module sb_reg_slot
    import sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LAT_W-1:0] load_wait,
    input  logic             load_fwd,
    output logic [LAT_W-1:0] cnt,
    output logic             fwd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            fwd <= 1'b0;
        end else if (load) begin
            cnt <= load_wait;
            fwd <= load_fwd;
        end else begin
            if (cnt != '0) begin
                cnt <= cnt - LAT_W'(1);
            end
            fwd <= 1'b0;
        end
    end

endmodule

// File: rtl/sb_hold_ctr.sv
module sb_hold_ctr
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [HOLD_W-1:0] fire_len,
    output logic              busy
);

    logic [HOLD_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= fire_len;
        end else if (left_q != '0) begin
            left_q <= left_q - HOLD_W'(1);
        end
    end

    assign busy = (left_q != '0);

endmodule

// File: rtl/sb_operand_check.sv
module sb_operand_check
    import sb_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic [LAT_W-1:0]          cnt [NREGS],
    input  logic [NREGS-1:0]          fwd,
    input  logic [NSRC-1:0][AW-1:0]   srcs,
    input  logic [NSRC-1:0]           src_en,
    input  logic                      store_op,
    input  logic                      data_flag,
    output logic                      all_ready
);

    localparam int DATA_SLOT = NSRC - 1;

    logic [NSRC-1:0] slot_ok;
    logic            addr_clash;
    logic            early_ok;

    always_comb begin
        addr_clash = 1'b0;
        for (int k = 0; k < DATA_SLOT; k++) begin
            if (src_en[k] && (srcs[k] == srcs[DATA_SLOT])) begin
                addr_clash = 1'b1;
            end
        end
    end

    assign early_ok = store_op && data_flag && src_en[DATA_SLOT] && !addr_clash
                      && fwd[srcs[DATA_SLOT]]
                      && (cnt[srcs[DATA_SLOT]] == LAT_W'(1));

    generate
        for (genvar k = 0; k < NSRC; k++) begin : g_slot
            if (k == DATA_SLOT) begin : g_data
                assign slot_ok[k] = !src_en[k] || (cnt[srcs[k]] == '0) || early_ok;
            end else begin : g_addr
                assign slot_ok[k] = !src_en[k] || (cnt[srcs[k]] == '0);
            end
        end
    endgenerate

    assign all_ready = &slot_ok;

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import sb_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       in_class,
    input  logic [AW-1:0]    in_dst,
    input  logic             in_dst_en,
    input  logic [AW-1:0]    in_src0,
    input  logic [AW-1:0]    in_src1,
    input  logic [AW-1:0]    in_src2,
    input  logic [2:0]       in_src_en,
    input  logic             in_src2_data,
    output logic             out_issue,
    output logic             out_stall,
    output logic [NREGS-1:0] out_ready
);

    cls_info_t             info;
    logic [LAT_W-1:0]      cnt [NREGS];
    logic [NREGS-1:0]      fwd;
    logic [NSRC-1:0][AW-1:0] srcs;
    logic                  ops_ok;
    logic                  busy;
    logic                  do_write;

    assign info     = cls_lookup(in_class);
    assign srcs     = {in_src2, in_src1, in_src0};
    assign out_issue = in_valid && !busy && ops_ok;
    assign out_stall = in_valid && !out_issue;
    assign do_write  = out_issue && info.writes && in_dst_en;

    sb_operand_check #(
        .NREGS (NREGS),
        .AW    (AW)
    ) u_check (
        .cnt       (cnt),
        .fwd       (fwd),
        .srcs      (srcs),
        .src_en    (in_src_en),
        .store_op  (is_store(in_class)),
        .data_flag (in_src2_data),
        .all_ready (ops_ok)
    );

    sb_hold_ctr u_hold (
        .clk      (clk),
        .rst      (rst),
        .fire     (out_issue),
        .fire_len (info.hold_cyc),
        .busy     (busy)
    );

    generate
        for (genvar i = 0; i < NREGS; i++) begin : g_reg
            sb_reg_slot u_slot (
                .clk       (clk),
                .rst       (rst),
                .load      (do_write && (in_dst == AW'(i))),
                .load_wait (info.wait_cyc),
                .load_fwd  (info.fwd_store),
                .cnt       (cnt[i]),
                .fwd       (fwd[i])
            );
            assign out_ready[i] = (cnt[i] == '0);
        end
    endgenerate

endmodule

// File: rtl/issue_scoreboard_chk.sv
module issue_scoreboard_chk
    import sb_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int AW    = $clog2(NREGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [3:0]       in_class,
    input logic [AW-1:0]    in_dst,
    input logic             in_dst_en,
    input logic             out_issue,
    input logic             out_stall,
    input logic [NREGS-1:0] out_ready
);

    AST_ISSUE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_issue |-> in_valid); // R2

    AST_STALL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        out_stall |-> (in_valid && !out_issue)); // R2

    AST_IDLE_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && (&out_ready)) |=> (&out_ready)); // R2

    AST_RESET_ALL_READY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&out_ready)); // R1

    AST_ALU_READY_NEXT: assert property (@(posedge clk) disable iff (rst)
        (out_issue && in_class == CLS_ALU && in_dst_en) |=> out_ready[$past(in_dst)]); // R3

    AST_SHIFT_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (rst)
        (out_issue && in_class == CLS_SHREG) |=> !out_issue); // R4

    AST_LOAD_PENDING: assert property (@(posedge clk) disable iff (rst)
        (out_issue && in_class == CLS_LD1 && in_dst_en) |=> !out_ready[$past(in_dst)]); // R5

    AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (out_issue && in_class == CLS_ST && out_ready[in_dst]) |=> out_ready[$past(in_dst)]); // R7

endmodule

bind issue_scoreboard issue_scoreboard_chk #(
    .NREGS (NREGS),
    .AW    (AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .in_dst    (in_dst),
    .in_dst_en (in_dst_en),
    .out_issue (out_issue),
    .out_stall (out_stall),
    .out_ready (out_ready)
);

// File: tb/issue_scoreboard_tb.sv
module issue_scoreboard_tb;

    localparam int NREGS = 16;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [3:0]       in_class = '0;
    logic [AW-1:0]    in_dst = '0;
    logic             in_dst_en = 1'b0;
    logic [AW-1:0]    in_src0 = '0;
    logic [AW-1:0]    in_src1 = '0;
    logic [AW-1:0]    in_src2 = '0;
    logic [2:0]       in_src_en = '0;
    logic             in_src2_data = 1'b0;
    logic             out_issue;
    logic             out_stall;
    logic [NREGS-1:0] out_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit               issue;
        bit               stall;
        logic [NREGS-1:0] care;
        logic [NREGS-1:0] rdy;
        string            tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    issue_scoreboard #(.NREGS(NREGS), .AW(AW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_class     (in_class),
        .in_dst       (in_dst),
        .in_dst_en    (in_dst_en),
        .in_src0      (in_src0),
        .in_src1      (in_src1),
        .in_src2      (in_src2),
        .in_src_en    (in_src_en),
        .in_src2_data (in_src2_data),
        .out_issue    (out_issue),
        .out_stall    (out_stall),
        .out_ready    (out_ready)
    );

    task automatic drive(input bit v, input int cls, input int dst, input bit den,
                         input int s0, input int s1, input int s2,
                         input logic [2:0] en, input bit df, input bit xi,
                         input logic [NREGS-1:0] care, input logic [NREGS-1:0] rdy,
                         input string tag);
        exp_t e;
        @(negedge clk);
        in_valid     = v;
        in_class     = 4'(cls);
        in_dst       = AW'(dst);
        in_dst_en    = den;
        in_src0      = AW'(s0);
        in_src1      = AW'(s1);
        in_src2      = AW'(s2);
        in_src_en    = en;
        in_src2_data = df;
        e.issue = xi;
        e.stall = v && !xi;
        e.care  = care;
        e.rdy   = rdy;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic op(input int cls, input int dst, input bit den,
                      input int s0, input int s1, input int s2,
                      input logic [2:0] en, input bit df, input bit xi,
                      input logic [NREGS-1:0] care, input logic [NREGS-1:0] rdy,
                      input string tag);
        drive(1'b1, cls, dst, den, s0, s1, s2, en, df, xi, care, rdy, tag);
    endtask

    task automatic idle(input logic [NREGS-1:0] care, input logic [NREGS-1:0] rdy,
                        input string tag);
        drive(1'b0, 0, 0, 1'b0, 0, 0, 0, 3'b000, 1'b0, 1'b0, care, rdy, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Monitor: pops one expected item per driven cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (out_issue !== e.issue || out_stall !== e.stall ||
                    (out_ready & e.care) !== (e.rdy & e.care)) begin
                    fails++;
                    $display("FAIL %s: issue=%0b stall=%0b ready=%h exp issue=%0b stall=%0b ready=%h (mask %h)",
                             e.tag, out_issue, out_stall, out_ready & e.care,
                             e.issue, e.stall, e.rdy & e.care, e.care);
                end
            end
        end
    end

    initial begin
        #(10 * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, exp %0d pending", exp_q.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        idle(16'hFFFF, 16'hFFFF, "R1 reset state");
        op(0, 1, 1, 2, 3, 0, 3'b011, 0, 1, 0, 0, "R2 first ALU");
        op(0, 4, 1, 1, 0, 0, 3'b001, 0, 1, 16'h0002, 16'h0002, "R3 ALU next cycle");
        op(2, 5, 1, 4, 0, 0, 3'b001, 0, 1, 0, 0, "R3 load uses ALU result");
        op(0, 6, 1, 5, 0, 0, 3'b001, 0, 0, 16'h0020, 16'h0000, "R5 load not ready at +1");
        op(0, 6, 1, 5, 0, 0, 3'b001, 0, 1, 16'h0020, 16'h0020, "R5 load ready at +2");

        // R6 early store-data use
        op(2, 7, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R6 load");
        op(5, 0, 0, 1, 0, 7, 3'b101, 1, 1, 16'h0080, 16'h0000, "R6 store data bypass / R11");
        op(2, 8, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R6 load");
        op(5, 0, 0, 8, 0, 8, 3'b101, 1, 0, 0, 0, "R6 address clash stalls");
        op(5, 0, 0, 8, 0, 8, 3'b101, 1, 1, 0, 0, "R6 address clash retry");
        op(2, 9, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R6 load");
        op(0, 10, 1, 0, 0, 9, 3'b100, 1, 0, 0, 0, "R6 non-store gets no bypass");
        op(0, 10, 1, 0, 0, 9, 3'b100, 1, 1, 0, 0, "R6 non-store retry");
        op(3, 11, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R5 two-reg load");
        op(5, 0, 0, 1, 0, 11, 3'b101, 1, 0, 0, 0, "R6 two-reg load no bypass");
        op(5, 0, 0, 1, 0, 11, 3'b101, 1, 1, 0, 0, "R5 two-reg load ready at +2");

        // R4 register shift
        op(1, 12, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R4 shift by register");
        op(0, 13, 1, 12, 0, 0, 3'b001, 0, 0, 16'h1000, 16'h0000, "R4 hold cycle");
        op(0, 13, 1, 12, 0, 0, 3'b001, 0, 1, 16'h1000, 16'h1000, "R4 issue at +2");

        // R5 multi-register load, R9 counting under hold
        op(4, 3, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R5 multi-reg load");
        op(0, 14, 1, 3, 0, 0, 3'b001, 0, 0, 0, 0, "R5 multi-reg hold 1");
        op(0, 14, 1, 3, 0, 0, 3'b001, 0, 0, 16'h0008, 16'h0000, "R9 hold 2");
        op(0, 14, 1, 3, 0, 0, 3'b001, 0, 1, 16'h0008, 16'h0008, "R9 ready as hold ends");

        // R8 multiply classes
        op(9, 15, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R8 long mul");
        op(0, 0, 1, 15, 0, 0, 3'b001, 0, 0, 0, 0, "R8 long mul +1");
        op(0, 0, 1, 15, 0, 0, 3'b001, 0, 0, 0, 0, "R8 long mul +2");
        op(0, 0, 1, 15, 0, 0, 3'b001, 0, 0, 16'h8000, 16'h0000, "R8 long mul +3");
        op(0, 0, 1, 15, 0, 0, 3'b001, 0, 1, 16'h8000, 16'h8000, "R8 long mul +4");
        op(8, 2, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R8 flag mul");
        op(0, 0, 1, 5, 0, 0, 3'b001, 0, 0, 0, 0, "R8 flag mul hold 1");
        op(0, 0, 1, 5, 0, 0, 3'b001, 0, 0, 0, 0, "R8 flag mul hold 2");
        op(0, 0, 1, 5, 0, 0, 3'b001, 0, 0, 16'h0004, 16'h0004, "R8 flag mul hold 3");
        op(0, 0, 1, 5, 0, 0, 3'b001, 0, 1, 0, 0, "R8 flag mul free");
        op(0, 1, 1, 2, 0, 0, 3'b001, 0, 1, 0, 0, "R8 flag mul result");
        op(7, 5, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R8 mul");
        op(0, 6, 1, 5, 0, 0, 3'b001, 0, 0, 0, 0, "R8 mul +1");
        op(0, 6, 1, 5, 0, 0, 3'b001, 0, 0, 0, 0, "R8 mul +2");
        op(0, 6, 1, 5, 0, 0, 3'b001, 0, 1, 0, 0, "R8 mul +3");
        op(6, 5, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R8 halfword mul");
        op(0, 6, 1, 5, 0, 0, 3'b001, 0, 0, 0, 0, "R8 halfword mul +1");
        op(0, 6, 1, 5, 0, 0, 3'b001, 0, 1, 0, 0, "R8 halfword mul +2");
        op(10, 5, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R8 long flag mul");
        for (int k = 1; k <= 4; k++) begin
            op(0, 6, 1, 5, 0, 0, 3'b001, 0, 0, 0, 0, "R8 long flag mul held");
        end
        op(0, 6, 1, 5, 0, 0, 3'b001, 0, 1, 0, 0, "R8 long flag mul +5");

        // R10 register 0, overwrite, disabled write
        op(2, 0, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R10 load into r0");
        op(0, 1, 1, 0, 0, 0, 3'b001, 0, 0, 16'h0001, 16'h0000, "R10 r0 tracked");
        op(0, 1, 1, 0, 0, 0, 3'b001, 0, 1, 16'h0001, 16'h0001, "R10 r0 ready");
        op(2, 6, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R10 load r6");
        op(0, 6, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R10 ALU overwrites r6");
        op(0, 7, 1, 6, 0, 0, 3'b001, 0, 1, 16'h0040, 16'h0040, "R10 newest wins");
        op(2, 9, 0, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R10 load with write off");
        op(0, 10, 1, 9, 0, 0, 3'b001, 0, 1, 16'h0200, 16'h0200, "R10 no tracking");

        // R7 store destination ignored
        op(5, 9, 1, 1, 0, 2, 3'b101, 1, 1, 0, 0, "R7 store");
        op(0, 10, 1, 9, 0, 0, 3'b001, 0, 1, 16'h0200, 16'h0200, "R7 store wrote nothing");

        // R2 invalid slot has no effect
        drive(1'b0, 2, 9, 1'b1, 1, 0, 0, 3'b001, 1'b0, 1'b0, 0, 0, "R2 invalid load");
        op(0, 10, 1, 9, 0, 0, 3'b001, 0, 1, 16'h0200, 16'h0200, "R2 invalid had no effect");

        // R3 unused code behaves as ALU
        op(12, 9, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R3 unused class");
        op(0, 10, 1, 9, 0, 0, 3'b001, 0, 1, 0, 0, "R3 unused class ready at +1");

        // R1 reset mid-flight
        op(4, 4, 1, 1, 0, 0, 3'b001, 0, 1, 0, 0, "R1 pending before reset");
        do_reset();
        idle(16'hFFFF, 16'hFFFF, "R1 all ready after reset");
        op(0, 5, 1, 4, 0, 0, 3'b001, 0, 1, 0, 0, "R1 hold cleared by reset");
        idle(16'hFFFF, 16'hFFFF, "R1 final idle");

        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule